// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing controller of a byte-addressed nonvolatile memory that answers on a two-wire serial bus (I2C-style signalling). It oversamples the clock and data lines with the system clock and recognises START and STOP conditions. It checks a select byte against a fixed device code and three strap inputs. After that it either loads a two-byte word pointer and stores incoming data, or sends stored bytes back to the master. The data line is driven only as an open-drain pull-down enable. The pad itself belongs to the surrounding chip.

Storage lives outside the block, behind a simple port with these signals:
- a word address, which is the internal pointer;
- a one-cycle write strobe, with the byte to store;
- read data, which must be valid in the same cycle as the address;
- a busy flag that the back end raises during its internal program cycle.

While busy is high, the controller refuses its select byte. A master can therefore poll for completion with a write select until it is acknowledged. A write-protect input lets the select and address phases finish normally but refuses the first data byte.

Top module: `i2c_mem_slave`

## Requirements
- R1: A fall of SDA while SCL is high is a START. It restarts select-byte reception from any state, including mid-byte. A rise of SDA while SCL is high is a STOP. It returns the controller to idle. Both release SDA, and a byte cut short by either is never stored.
- R2: The select byte is received MSB first as 1010, then three device bits, then R/W (1 = read, 0 = write). The controller pulls SDA low on the ninth clock only when the code matches, the three bits equal `strap_i[2:0]` (bit 2 first) and the back end is not busy. Otherwise there is no acknowledge, and the bus is ignored until the next START.
- R3: After a write select, two address bytes follow, high byte first, and each is acknowledged. The pointer takes the low ADDR_W-8 bits of the high byte and all of the low byte. The unused top bits of the high byte (4 bits for 4096 bytes) are ignored.
- R4: In a write, each further complete byte is acknowledged. It is issued as a single-cycle `mem_we_o` with `mem_addr_o` equal to the pointer and `mem_wdata_o` equal to the byte. The pointer then advances by one.
- R5: With `wp_i` high, the select and address bytes are acknowledged. The first data byte is not acknowledged, `mem_we_o` never rises, and the controller waits for the next START.
- R6: After a read select, the byte at the pointer is sent MSB first, and the pointer advances after each byte. A low acknowledge from the master continues with the next byte. A high one makes the controller release SDA until START or STOP. A read select without an address phase starts at the current pointer.
- R7: A write select plus address, then a repeated START with a read select and no STOP in between, reads from the given address.
- R8: The pointer wraps from MEM_BYTES-1 to 0 when it advances.
- R9: While `mem_busy_i` is high when the select byte completes, no acknowledge is given. The same select is acknowledged once busy has cleared.
- R10: `sda_oe_o` changes only while SCL is low.
- R11: After reset, `sda_oe_o` and `mem_we_o` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| strap_i | input | 3 | Device select bits matched against the select byte |
| wp_i | input | 1 | Write protect, 1 = refuse data bytes |
| mem_busy_i | input | 1 | Back end is in its internal program cycle |
| mem_addr_o | output | ADDR_W | Word pointer for both reads and writes |
| mem_wdata_o | output | 8 | Byte to store |
| mem_we_o | output | 1 | Single-cycle store strobe |
| mem_rdata_i | input | 8 | Byte at `mem_addr_o`, valid in the same cycle |

## Verification
The assertions assume the following about the inputs:
- every SCL low phase outlasts the synchronizer delay plus one register, so the enable change that follows a falling edge lands while SCL is still low;
- the master moves SDA only in the middle of SCL low, except for START and STOP;
- `wp_i` and the straps stay put while a byte is in flight.

The stimulus keeps these conditions by driving ten-cycle half periods and moving SDA five cycles into each low phase. It does not issue START or STOP while the controller is acknowledging or sending.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    // fixed upper nibble of the select byte
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } st_e;

endpackage

// File: rtl/i2c_mem_linesync.sv
module i2c_mem_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic prev_o
);

    // STAGES flops for metastability, one more to hold the previous value
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign q_o    = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/i2c_mem_cond.sv
module i2c_mem_cond (
    input  logic scl_now,
    input  logic scl_prev,
    input  logic sda_now,
    input  logic sda_prev,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic scl_held;

    always_comb begin
        scl_held = scl_now & scl_prev;
        start_o  = scl_held & sda_prev & ~sda_now;
        stop_o   = scl_held & ~sda_prev & sda_now;
        rise_o   = scl_now & ~scl_prev;
        fall_o   = ~scl_now & scl_prev;
    end

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter  int MEM_BYTES   = 4096,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              wp_i,
    input  logic              mem_busy_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    input  logic [7:0]        mem_rdata_i
);

    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        st_e               st;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              rw;
        logic              mack;
        logic              oe;
        logic              we;
        logic [ADDR_W-1:0] ptr;
    } regs_t;

    regs_t s_d, s_q;

    // index 0 = SCL, index 1 = SDA
    logic [1:0] line_raw, line_now, line_prev;
    logic       start_w, stop_w, rise_w, fall_w;
    logic       sel_ok;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_mem_linesync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (line_raw[g]),
            .q_o    (line_now[g]),
            .prev_o (line_prev[g])
        );
    end

    i2c_mem_cond u_cond (
        .scl_now  (line_now[0]),
        .scl_prev (line_prev[0]),
        .sda_now  (line_now[1]),
        .sda_prev (line_prev[1]),
        .start_o  (start_w),
        .stop_o   (stop_w),
        .rise_o   (rise_w),
        .fall_o   (fall_w)
    );

    assign sel_ok = (s_q.sh[7:4] == DEV_CODE) && (s_q.sh[3:1] == strap_i) && !mem_busy_i;

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (start_w) begin
            s_d.st  = ST_DEV;
            s_d.cnt = 4'd0;
            s_d.oe  = 1'b0;
        end else if (stop_w) begin
            s_d.st  = ST_IDLE;
            s_d.cnt = 4'd0;
            s_d.oe  = 1'b0;
        end else if (s_q.st != ST_IDLE) begin
            if (rise_w) begin
                if (s_q.cnt < 4'd8) begin
                    if (s_q.st != ST_RD) s_d.sh = {s_q.sh[6:0], line_now[1]};
                    s_d.cnt = s_q.cnt + 4'd1;
                end else if (s_q.cnt == 4'd8) begin
                    s_d.cnt = 4'd9;
                    if (s_q.st == ST_RD) s_d.mack = ~line_now[1];
                end
            end else if (fall_w) begin
                case (s_q.cnt)
                    4'd8: begin
                        // byte complete: decide acknowledge
                        case (s_q.st)
                            ST_DEV: begin
                                if (sel_ok) begin
                                    s_d.oe = 1'b1;
                                    s_d.rw = s_q.sh[0];
                                end else begin
                                    s_d.st = ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                s_d.oe  = 1'b1;
                                s_d.ptr = {s_q.sh[HI_W-1:0], s_q.ptr[7:0]};
                            end
                            ST_ALO: begin
                                s_d.oe  = 1'b1;
                                s_d.ptr = {s_q.ptr[ADDR_W-1:8], s_q.sh};
                            end
                            ST_WR: begin
                                if (wp_i) begin
                                    s_d.st = ST_IDLE;
                                end else begin
                                    s_d.oe = 1'b1;
                                    s_d.we = 1'b1;
                                end
                            end
                            ST_RD: begin
                                s_d.oe  = 1'b0;
                                s_d.ptr = s_q.ptr + 1'b1;
                            end
                            default: s_d.st = ST_IDLE;
                        endcase
                    end
                    4'd9: begin
                        // end of acknowledge clock
                        s_d.cnt = 4'd0;
                        s_d.oe  = 1'b0;
                        case (s_q.st)
                            ST_DEV: begin
                                if (s_q.rw) begin
                                    s_d.st = ST_RD;
                                    s_d.sh = mem_rdata_i;
                                    s_d.oe = ~mem_rdata_i[7];
                                end else begin
                                    s_d.st = ST_AHI;
                                end
                            end
                            ST_AHI: s_d.st = ST_ALO;
                            ST_ALO: s_d.st = ST_WR;
                            ST_WR:  s_d.ptr = s_q.ptr + 1'b1;
                            ST_RD: begin
                                if (s_q.mack) begin
                                    s_d.sh = mem_rdata_i;
                                    s_d.oe = ~mem_rdata_i[7];
                                end else begin
                                    s_d.st = ST_IDLE;
                                end
                            end
                            default: s_d.st = ST_IDLE;
                        endcase
                    end
                    default: begin
                        if (s_q.st == ST_RD && s_q.cnt != 4'd0) begin
                            s_d.sh = {s_q.sh[6:0], 1'b0};
                            s_d.oe = ~s_q.sh[6];
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: 4'd0, sh: 8'd0, rw: 1'b0, mack: 1'b0,
                     oe: 1'b0, we: 1'b0, ptr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe_o    = s_q.oe;
    assign mem_we_o    = s_q.we;
    assign mem_addr_o  = s_q.ptr;
    assign mem_wdata_o = s_q.sh;

endmodule

// File: rtl/i2c_mem_chk.sv
module i2c_mem_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic wp_i,
    input logic sda_oe_o,
    input logic mem_we_o,
    input logic start_det,
    input logic stop_det
);

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    // R5
    wp_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(!wp_i));

endmodule

bind i2c_mem_slave i2c_mem_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .wp_i      (wp_i),
    .sda_oe_o  (sda_oe_o),
    .mem_we_o  (mem_we_o),
    .start_det (start_w),
    .stop_det  (stop_w)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb_top;

    localparam int MB    = 4096;
    localparam int AW    = 12;
    localparam int Q     = 5;
    localparam int BUSY  = 300;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe, mem_we, mem_busy;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic sda_line;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_mem_slave #(.MEM_BYTES(MB)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_i     (STRAP),
        .wp_i        (wp),
        .mem_busy_i  (mem_busy),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_rdata_i (mem_rdata)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(a * 37 + (a >> 8) + 11);
    endfunction

    // storage back end model
    logic [7:0] mem [MB];
    int busy_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MB; i++) mem[i] <= pat(i);
            busy_cnt <= 0;
        end else begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                busy_cnt <= BUSY;
            end else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end
    assign mem_busy  = (busy_cnt != 0);
    assign mem_rdata = mem[mem_addr];

    // port monitors, sampled on the falling clock edge
    int we_cnt = 0;
    int last_waddr = 0;
    int last_wdata = 0;
    int r10_bad = 0;
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                we_cnt++;
                last_waddr = int'(mem_addr);
                last_wdata = int'(mem_wdata);
            end
            if (sda_oe != prev_oe && scl_m) r10_bad++;
        end
        prev_oe = sda_oe;
    end

    logic [7:0] exp_mem [MB];
    int n_tests = 0;
    int n_fail = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(bit b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbyte(output logic [7:0] b, input bit mack);
        sda_m = 1'b1;
        b = 8'd0;
        for (int i = 0; i < 8; i++) begin
            tick(2 * Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_line}; tick(Q);
            scl_m = 1'b0;
        end
        send_bit(!mack);
        sda_m = 1'b1;
    endtask

    task automatic sel(logic [2:0] st, bit rd, output bit ack);
        bstart();
        wbyte({4'b1010, st, rd}, ack);
    endtask

    task automatic set_addr(int a, output bit ok);
        bit k0, k1, k2;
        sel(STRAP, 1'b0, k0);
        wbyte({4'($urandom), 4'(a >> 8)}, k1);
        wbyte(8'(a), k2);
        ok = k0 && k1 && k2;
    endtask

    task automatic write_seq(int a, int n, string req);
        bit ok, k;
        set_addr(a, ok);
        chk(ok, "R3", "address phase acked", int'(ok), 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            wbyte(d, k);
            chk(k, req, "data byte acked", int'(k), 1);
            exp_mem[(a + i) % MB] = d;
        end
        bstop();
        tick(BUSY + 100);
    endtask

    task automatic read_seq(int a, int n, string req);
        bit ok, k;
        logic [7:0] b;
        set_addr(a, ok);
        sel(STRAP, 1'b1, k);
        chk(ok && k, "R7", "repeated start read select acked", int'(ok && k), 1);
        for (int i = 0; i < n; i++) begin
            rbyte(b, i < n - 1);
            chk(b == exp_mem[(a + i) % MB], req, "read data", int'(b), int'(exp_mem[(a + i) % MB]));
        end
        bstop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit k, ok;
        logic [7:0] b;
        int base;
        void'($urandom(32'd4711));
        for (int i = 0; i < MB; i++) exp_mem[i] = pat(i);
        tick(6);
        rst_n = 1'b1;
        tick(2);

        // R11 reset state
        chk(sda_oe == 1'b0, "R11", "oe after reset", int'(sda_oe), 0);
        chk(mem_we == 1'b0, "R11", "we after reset", int'(mem_we), 0);
        chk(mem_addr == '0, "R11", "pointer after reset", int'(mem_addr), 0);

        // R2 select decoding
        bstart(); wbyte(8'b1011_1010, k); bstop();
        chk(!k, "R2", "wrong device code nacked", int'(k), 0);
        sel(STRAP ^ 3'b010, 1'b0, k); bstop();
        chk(!k, "R2", "wrong strap nacked", int'(k), 0);
        sel(STRAP, 1'b0, k); bstop();
        chk(k, "R2", "matching select acked", int'(k), 1);

        // R3 R4 byte write with don't-care high bits set
        set_addr(12'h3A5, ok);
        chk(ok, "R3", "address acked", int'(ok), 1);
        wbyte(8'hC3, k);
        chk(k, "R4", "data acked", int'(k), 1);
        bstop();
        exp_mem[12'h3A5] = 8'hC3;
        chk(we_cnt == 1, "R4", "single store strobe", we_cnt, 1);
        chk(last_waddr == 12'h3A5, "R3", "store address ignores top bits", last_waddr, 12'h3A5);
        chk(last_wdata == 8'hC3, "R4", "store data", last_wdata, 8'hC3);

        // R9 busy polling right after the write
        sel(STRAP, 1'b0, k); bstop();
        chk(!k, "R9", "select nacked while busy", int'(k), 0);
        tick(BUSY + 100);
        sel(STRAP, 1'b0, k); bstop();
        chk(k, "R9", "select acked after busy", int'(k), 1);

        // R4 multi-byte write then R6 sequential read back
        write_seq(12'h7F0, 4, "R4");
        read_seq(12'h7EF, 6, "R6");

        // R6 current address read continues after the last byte sent (0x7F5)
        sel(STRAP, 1'b1, k);
        rbyte(b, 1'b0);
        bstop();
        chk(k, "R6", "current read select acked", int'(k), 1);
        chk(b == exp_mem[12'h7F5], "R6", "current address data", int'(b), int'(exp_mem[12'h7F5]));

        // R6 master nack releases the line
        set_addr(12'h100, ok);
        sel(STRAP, 1'b1, k);
        rbyte(b, 1'b0);
        chk(b == exp_mem[12'h100], "R7", "random read data", int'(b), int'(exp_mem[12'h100]));
        rbyte(b, 1'b0);
        bstop();
        chk(b == 8'hFF, "R6", "line released after nack", int'(b), 8'hFF);

        // R5 write protect
        base = we_cnt;
        wp = 1'b1;
        set_addr(12'h200, ok);
        chk(ok, "R5", "address acked under protect", int'(ok), 1);
        wbyte(8'h00, k);
        bstop();
        wp = 1'b0;
        chk(!k, "R5", "data nacked under protect", int'(k), 0);
        chk(we_cnt == base, "R5", "no store under protect", we_cnt, base);
        read_seq(12'h200, 1, "R5");

        // R8 pointer wrap
        read_seq(MB - 2, 4, "R8");

        // R1 START mid-byte restarts select reception
        bstart();
        for (int i = 0; i < 4; i++) send_bit(i[0]);
        sel(STRAP, 1'b0, k); bstop();
        chk(k, "R1", "select after mid-byte restart acked", int'(k), 1);

        // R1 STOP mid data byte stores nothing
        base = we_cnt;
        set_addr(12'h300, ok);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bstop();
        chk(we_cnt == base, "R1", "no store after aborted byte", we_cnt, base);
        read_seq(12'h300, 1, "R1");

        // random traffic
        for (int it = 0; it < 6; it++) begin
            int a, n;
            a = int'($urandom % MB);
            n = 1 + int'($urandom % 4);
            write_seq(a, n, "R4");
            read_seq(a, n, "R6");
        end

        chk(r10_bad == 0, "R10", "oe changes while SCL high", r10_bad, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule